// File: doc/BRIEF.md
# Configuration transaction command controller

This block turns a three-register software interface into single transactions on a downstream request/acknowledge port. Software first fills the data register, then clears the status register, and finally writes a control word with its top bit set. That write launches one read or one write. The target of the transaction is a packed address built from five fields of the control word: channel, function, site, position and device.

While the transaction is in flight, the start bit reads back as 1 and the block refuses every register write. The transaction can end in one of three ways: an acknowledge, an error response, or a response timeout that the block counts itself. On that same clock edge the block clears start and sets exactly one status bit. A successful read also loads the returned word into the data register on that edge. Software polls until start reads 0, or until status reads nonzero.

Top module: `cfg_txn_ctrl`

## Requirements
- R1: Byte addresses 0xA0 (data), 0xA4 (control) and 0xA8 (status) are decoded. A read strobe returns the register value on bus_rdata one clock later. Any other address reads as zero. After reset every register reads zero and dn_req is low.
- R2: The control word uses bit 31 for start, bit 30 for write, 29:26 for channel, 25:20 for function, 17:16 for site, 15:12 for position and 11:0 for device. A write with bit 31 set while idle raises dn_req in the next cycle. In that cycle dn_write equals bit 30, dn_tgt equals {channel[27:24], function[23:18], site[17:16], position[15:12], device[11:0]}, and dn_wdata equals the data register.
- R3: A control write with bit 31 clear while idle stores the fields and reads them back, but starts no transaction.
- R4: Start reads 1 exactly while a transaction is in flight. While it is 1, writes to any register are ignored, and a read shows the same values as before the write.
- R5: An acknowledge ends the transaction. On that edge start clears, status becomes 1 (bit 0, complete) and dn_req falls.
- R6: A successful read loads dn_rdata into the data register on the same edge that sets complete.
- R7: An error response ends the transaction with status 2 (bit 1, error) and leaves the data register unchanged.
- R8: If no acknowledge or error arrives within TIMEOUT_CYC cycles of dn_req being high, the transaction ends with status 2. An acknowledge sampled in the last of those cycles still completes with status 1.
- R9: A write transaction leaves the data register unchanged.
- R10: Control bits 19:18 read back as zero and have no effect on dn_tgt.
- R11: A status write while idle clears both bits, whatever value is written. At most one status bit is ever set.
- R12: If acknowledge and error are sampled together, error wins and status becomes 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Register byte address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_rd |
| dn_req | output | 1 | Downstream request, high while a transaction is in flight |
| dn_write | output | 1 | Transaction is a write |
| dn_tgt | output | 28 | Packed target address (channel, function, site, position, device) |
| dn_wdata | output | 32 | Write data for the transaction |
| dn_ack | input | 1 | Downstream acknowledge |
| dn_err | input | 1 | Downstream error response |
| dn_rdata | input | 32 | Read data, sampled with dn_ack |

## Verification
Two pairs of events can fall on one edge. The first pair is the timeout expiry and an acknowledge. The bench provokes it by holding back the acknowledge until the final cycle of the window, and judges it correct only if status reads 1 rather than 2. The second pair is an acknowledge and an error, driven in the same cycle. For that case the bench requires status 2, with the data register left as it was before the read.

// File: rtl/cfg_txn_pkg.sv
package cfg_txn_pkg;

  localparam int WORD_W = 32;
  localparam int TGT_W  = 28;

  // control word bit positions
  localparam int START_BIT = 31;
  localparam int WRITE_BIT = 30;

  typedef struct packed {
    logic        write;
    logic [3:0]  chan;
    logic [5:0]  func;
    logic [1:0]  site;
    logic [3:0]  pos;
    logic [11:0] dev;
  } cmd_t;

  typedef enum logic { ST_IDLE = 1'b0, ST_WAIT = 1'b1 } seq_state_t;

  // register select indices
  localparam int SEL_DATA = 0;
  localparam int SEL_CTRL = 1;
  localparam int SEL_STAT = 2;
  localparam int NSEL     = 3;

  function automatic cmd_t word_to_cmd(input logic [WORD_W-1:0] w);
    cmd_t c;
    c.write = w[WRITE_BIT];
    c.chan  = w[29:26];
    c.func  = w[25:20];
    c.site  = w[17:16];
    c.pos   = w[15:12];
    c.dev   = w[11:0];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] cmd_to_word(input logic start, input cmd_t c);
    return {start, c.write, c.chan, c.func, 2'b00, c.site, c.pos, c.dev};
  endfunction

  function automatic logic [TGT_W-1:0] cmd_to_tgt(input cmd_t c);
    return {c.chan, c.func, c.site, c.pos, c.dev};
  endfunction

endpackage

// File: rtl/cfg_reg_decode.sv
module cfg_reg_decode
  import cfg_txn_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DATA_OFS = 'hA0,
  parameter int CTRL_OFS = 'hA4,
  parameter int STAT_OFS = 'hA8
) (
  input  logic [AW-1:0]   addr,
  output logic [NSEL-1:0] sel
);

  localparam logic [AW-1:0] OFS_TAB [NSEL] = '{AW'(DATA_OFS), AW'(CTRL_OFS), AW'(STAT_OFS)};

  for (genvar g = 0; g < NSEL; g++) begin : g_hit
    assign sel[g] = (addr == OFS_TAB[g]);
  end

endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
  import cfg_txn_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic launch,
  input  logic rsp_ack,
  input  logic rsp_err,
  output logic req,
  output logic finish,
  output logic finish_ok
);

  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

  seq_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             waiting;
  logic             expired;

  assign waiting   = (state_q == ST_WAIT);
  assign expired   = (cnt_q == CNT_LAST);
  assign finish    = waiting && (rsp_ack || rsp_err || expired);
  // error has priority over acknowledge; ack beats an expiring window
  assign finish_ok = waiting && rsp_ack && !rsp_err;
  assign req       = waiting;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (launch) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (finish) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_txn_ctrl.sv
module cfg_txn_ctrl
  import cfg_txn_pkg::*;
#(
  parameter int AW          = 8,
  parameter int DATA_OFS    = 'hA0,
  parameter int CTRL_OFS    = 'hA4,
  parameter int STAT_OFS    = 'hA8,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              dn_req,
  output logic              dn_write,
  output logic [TGT_W-1:0]  dn_tgt,
  output logic [WORD_W-1:0] dn_wdata,
  input  logic              dn_ack,
  input  logic              dn_err,
  input  logic [WORD_W-1:0] dn_rdata
);

  logic [NSEL-1:0]   sel;
  logic              start_q;
  cmd_t              cmd_q;
  logic [WORD_W-1:0] data_q;
  logic [1:0]        stat_q;
  logic [WORD_W-1:0] rdata_q;
  logic              launch;
  logic              fin, fin_ok;
  logic              wr_ok;

  cfg_reg_decode #(
    .AW(AW), .DATA_OFS(DATA_OFS), .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS)
  ) u_dec (
    .addr(bus_addr),
    .sel (sel)
  );

  assign wr_ok  = bus_wr && !start_q;
  assign launch = wr_ok && sel[SEL_CTRL] && bus_wdata[START_BIT];

  cfg_seq_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .launch   (launch),
    .rsp_ack  (dn_ack),
    .rsp_err  (dn_err),
    .req      (dn_req),
    .finish   (fin),
    .finish_ok(fin_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      cmd_q   <= '0;
      data_q  <= '0;
      stat_q  <= 2'b00;
    end else if (fin) begin
      start_q <= 1'b0;
      stat_q  <= fin_ok ? 2'b01 : 2'b10;
      if (fin_ok && !cmd_q.write) data_q <= dn_rdata;
    end else if (wr_ok) begin
      if (sel[SEL_DATA]) data_q <= bus_wdata;
      if (sel[SEL_STAT]) stat_q <= 2'b00;
      if (sel[SEL_CTRL]) begin
        cmd_q   <= word_to_cmd(bus_wdata);
        start_q <= bus_wdata[START_BIT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      unique case (1'b1)
        sel[SEL_DATA]: rdata_q <= data_q;
        sel[SEL_CTRL]: rdata_q <= cmd_to_word(start_q, cmd_q);
        sel[SEL_STAT]: rdata_q <= {{(WORD_W-2){1'b0}}, stat_q};
        default:       rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign dn_write  = cmd_q.write;
  assign dn_tgt    = cmd_to_tgt(cmd_q);
  assign dn_wdata  = data_q;

endmodule

// File: rtl/cfg_txn_ctrl_chk.sv
module cfg_txn_ctrl_chk #(
  parameter int TIMEOUT_CYC = 64
) (
  input logic        clk,
  input logic        rst,
  input logic        start_q,
  input logic [1:0]  stat_q,
  input logic [31:0] data_q,
  input logic        dn_req,
  input logic        dn_write,
  input logic        dn_ack,
  input logic        dn_err,
  input logic [31:0] dn_rdata
);

  int unsigned wait_cnt;

  always_ff @(posedge clk) begin
    if (rst || !dn_req) wait_cnt <= 0;
    else                wait_cnt <= wait_cnt + 1;
  end

  assert_launch_req_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(dn_req) |-> start_q);

  assert_start_tracks_req_R4: assert property (@(posedge clk) disable iff (rst)
    start_q == dn_req);

  assert_end_sets_status_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(start_q) |-> stat_q != 2'b00);

  assert_read_load_R6: assert property (@(posedge clk) disable iff (rst)
    dn_req && !dn_write && dn_ack && !dn_err |=> data_q == $past(dn_rdata));

  assert_err_end_R7: assert property (@(posedge clk) disable iff (rst)
    dn_req && dn_err |=> stat_q == 2'b10 && !dn_req);

  assert_window_R8: assert property (@(posedge clk) disable iff (rst)
    dn_req |-> wait_cnt < TIMEOUT_CYC);

  assert_data_hold_R9: assert property (@(posedge clk) disable iff (rst)
    dn_req && (dn_write || !dn_ack || dn_err) |=> $stable(data_q));

  assert_status_onehot_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stat_q));

endmodule

bind cfg_txn_ctrl cfg_txn_ctrl_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start_q (start_q),
  .stat_q  (stat_q),
  .data_q  (data_q),
  .dn_req  (dn_req),
  .dn_write(dn_write),
  .dn_ack  (dn_ack),
  .dn_err  (dn_err),
  .dn_rdata(dn_rdata)
);

// File: tb/cfg_txn_ctrl_bench.sv
`timescale 1ns/1ps
module cfg_txn_ctrl_bench;

  localparam int TMO = 16;
  localparam logic [7:0] A_DATA = 8'hA0, A_CTRL = 8'hA4, A_STAT = 8'hA8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dn_req, dn_write;
  logic [27:0] dn_tgt;
  logic [31:0] dn_wdata;
  logic        dn_ack = 1'b0, dn_err = 1'b0;
  logic [31:0] dn_rdata = '0;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  cfg_txn_ctrl #(.TIMEOUT_CYC(TMO)) u_cfg_txn_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dn_req(dn_req), .dn_write(dn_write),
    .dn_tgt(dn_tgt), .dn_wdata(dn_wdata), .dn_ack(dn_ack), .dn_err(dn_err),
    .dn_rdata(dn_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  function automatic logic [31:0] mk_ctrl(input logic st, input logic wr, input logic [3:0] ch,
      input logic [5:0] fn, input logic [1:0] si, input logic [3:0] po, input logic [11:0] dv);
    return {st, wr, ch, fn, 2'b00, si, po, dv};
  endfunction

  // one-cycle response pulse, driven at negedge, sampled at next posedge
  task automatic respond(input logic a, input logic e, input logic [31:0] rd);
    dn_ack = a; dn_err = e; dn_rdata = rd;
    @(negedge clk); dn_ack = 1'b0; dn_err = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 reset req", {31'b0, dn_req}, 32'd0);
    reg_read(A_DATA, v); check("R1 reset data", v, 0);
    reg_read(A_CTRL, v); check("R1 reset ctrl", v, 0);
    reg_read(A_STAT, v); check("R1 reset stat", v, 0);
    reg_write(8'h10, 32'hFFFF_FFFF);
    reg_read(8'h10, v);  check("R1 unmapped", v, 0);
  endtask

  task automatic t_idle_store();
    logic [31:0] v, w;
    w = mk_ctrl(1'b0, 1'b1, 4'h3, 6'h11, 2'h1, 4'h7, 12'h055);
    reg_write(A_CTRL, w | 32'h000C_0000);
    check("R3 no launch", {31'b0, dn_req}, 0);
    reg_read(A_CTRL, v);
    check("R3 readback", v, w);
    check("R10 idle bits19:18", v & 32'h000C_0000, 0);
    check("R3 still idle", {31'b0, dn_req}, 0);
  endtask

  task automatic t_write_txn();
    logic [31:0] v, w;
    reg_write(A_DATA, 32'h1234_5678);
    reg_write(A_STAT, 32'h0);
    w = mk_ctrl(1'b1, 1'b1, 4'h5, 6'h2A, 2'h2, 4'h9, 12'hABC);
    reg_write(A_CTRL, w | 32'h000C_0000);
    check("R2 req", {31'b0, dn_req}, 1);
    check("R2 write", {31'b0, dn_write}, 1);
    check("R2 tgt R10", {4'b0, dn_tgt}, {4'b0, 4'h5, 6'h2A, 2'h2, 4'h9, 12'hABC});
    check("R2 wdata", dn_wdata, 32'h1234_5678);
    reg_read(A_CTRL, v);
    check("R4 start busy", v, w);
    reg_write(A_DATA, 32'hFFFF_0000);
    reg_write(A_CTRL, mk_ctrl(1'b1, 1'b0, 4'h1, 6'h1, 2'h1, 4'h1, 12'h1));
    check("R4 tgt kept", {4'b0, dn_tgt}, {4'b0, 4'h5, 6'h2A, 2'h2, 4'h9, 12'hABC});
    reg_read(A_DATA, v);
    check("R4 data kept", v, 32'h1234_5678);
    reg_read(A_STAT, v);
    check("R4 stat zero in flight", v, 0);
    respond(1'b1, 1'b0, 32'hDEAD_0001);
    check("R5 req dropped", {31'b0, dn_req}, 0);
    reg_read(A_STAT, v);  check("R5 complete", v, 1);
    reg_read(A_CTRL, v);  check("R5 start clear", v[31], 0);
    reg_read(A_DATA, v);  check("R9 data unchanged", v, 32'h1234_5678);
    reg_write(A_STAT, 32'hFFFF_FFFF);
    reg_read(A_STAT, v);  check("R11 status clear", v, 0);
  endtask

  task automatic t_read_ok();
    logic [31:0] v;
    reg_write(A_STAT, 0);
    reg_write(A_CTRL, mk_ctrl(1'b1, 1'b0, 4'h0, 6'h3, 2'h0, 4'h0, 12'h010));
    check("R2 read dir", {31'b0, dn_write}, 0);
    @(negedge clk);
    respond(1'b1, 1'b0, 32'hCAFE_F00D);
    reg_read(A_STAT, v); check("R6 complete", v, 1);
    reg_read(A_DATA, v); check("R6 read data", v, 32'hCAFE_F00D);
  endtask

  task automatic t_err();
    logic [31:0] v;
    reg_write(A_DATA, 32'h0BAD_0BAD);
    reg_write(A_STAT, 0);
    reg_write(A_CTRL, mk_ctrl(1'b1, 1'b0, 4'h2, 6'h4, 2'h3, 4'h2, 12'h020));
    respond(1'b0, 1'b1, 32'h5555_5555);
    reg_read(A_STAT, v); check("R7 error", v, 2);
    reg_read(A_DATA, v); check("R7 data kept", v, 32'h0BAD_0BAD);
  endtask

  task automatic t_ack_err();
    logic [31:0] v;
    reg_write(A_STAT, 0);
    reg_write(A_CTRL, mk_ctrl(1'b1, 1'b0, 4'h2, 6'h4, 2'h3, 4'h2, 12'h021));
    respond(1'b1, 1'b1, 32'h7777_7777);
    reg_read(A_STAT, v); check("R12 err wins", v, 2);
    reg_read(A_DATA, v); check("R12 data kept", v, 32'h0BAD_0BAD);
  endtask

  task automatic t_timeout();
    logic [31:0] v;
    int n = 0;
    reg_write(A_STAT, 0);
    reg_write(A_CTRL, mk_ctrl(1'b1, 1'b1, 4'h1, 6'h1, 2'h0, 4'h0, 12'h001));
    while (dn_req && n < 100) begin n++; @(negedge clk); end
    check("R8 window len", n, TMO);
    reg_read(A_STAT, v); check("R8 timeout err", v, 2);
  endtask

  task automatic t_ack_last();
    logic [31:0] v;
    reg_write(A_STAT, 0);
    reg_write(A_CTRL, mk_ctrl(1'b1, 1'b0, 4'h1, 6'h1, 2'h0, 4'h0, 12'h002));
    repeat (TMO - 1) @(negedge clk);
    check("R8 still waiting", {31'b0, dn_req}, 1);
    respond(1'b1, 1'b0, 32'h600D_600D);
    reg_read(A_STAT, v); check("R8 ack at last cycle", v, 1);
    reg_read(A_DATA, v); check("R8 last-cycle data", v, 32'h600D_600D);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_idle_store();
    t_write_txn();
    t_read_ok();
    t_err();
    t_ack_err();
    t_timeout();
    t_ack_last();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule